// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block sits beside the command scheduler of an SDRAM controller. It watches every command the scheduler registers, keeps a small state machine for each bank, and tells the scheduler which banks hold an open row, which row that is, and which banks cannot take a command yet. When a command arrives that the current bank state forbids, the tracker raises a one-cycle `cmd_illegal` pulse. It leaves its own state as it was, as though the command had never been sent.

Each bank walks through six named states:
- `BK_IDLE`: the row is closed.
- `BK_OPEN`: a row is open and no burst is running.
- `BK_BURST`: a fixed-length burst is running without auto precharge.
- `BK_BURST_AP`: a fixed-length burst is running with auto precharge armed.
- `BK_STREAM`: a full-page burst is running. It runs until it is cut off.
- `BK_RECOVER`: the precharge recovery window is counting down.

The transitions are:
- ACTIVATE takes `BK_IDLE` to `BK_OPEN`.
- READ or WRITE takes an open bank to `BK_BURST`, `BK_BURST_AP` or `BK_STREAM`, chosen by the full-page mode and the per-command auto-precharge flag.
- Burst expiry takes `BK_BURST` to `BK_OPEN` and `BK_BURST_AP` to `BK_RECOVER`.
- PRECHARGE takes `BK_OPEN`, `BK_BURST` or `BK_STREAM` to `BK_RECOVER`.
- BURST STOP takes `BK_BURST` or `BK_STREAM` to `BK_OPEN`.
- Recovery expiry takes `BK_RECOVER` to `BK_IDLE`.

The burst length, the recovery time, the bank count and the row width are elaboration parameters.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset every bank reads closed and not busy, every row output is zero, and `cmd_illegal` is low.
- R2: ACTIVATE (op 1) to a bank that is closed and not busy makes it open with `cmd_row` as its row on the next cycle. ACTIVATE to a bank that is open or recovering is illegal.
- R3: READ (op 2) or WRITE (op 3) to a bank that is closed, or to a bank that is busy, is illegal.
- R4: An illegal command gives `cmd_illegal` high for exactly the one cycle after it and changes no bank's open flag, row or busy flag. Bank timers that are already running keep counting.
- R5: A READ or WRITE with `cmd_ap` high in fixed-length mode keeps the bank open and busy for BURST_LEN cycles. The bank is then closed and busy for T_RP cycles, and then idle.
- R6: Auto precharge applies only to the command that carries it. A later READ or WRITE without the flag leaves the bank open and not busy once its burst ends.
- R7: With `full_page` high at a READ or WRITE, `cmd_ap` is ignored. The bank stays open and not busy indefinitely.
- R8: PRECHARGE (op 4) to an open bank that is not busy closes it and makes it busy for T_RP cycles. PRECHARGE to an idle bank has no effect. PRECHARGE to a busy bank is illegal.
- R9: BURST STOP (op 5) acts on the bank of the most recent accepted READ or WRITE, whatever `cmd_bank` says. It ends that burst and leaves the row open. It is illegal while that burst has auto precharge armed.
- R10: Op codes 0, 6 and 7, and any cycle with `cmd_valid` low, change nothing and never raise `cmd_illegal`.
- R11: Banks are independent. A burst or recovery in one bank runs to completion while other banks receive commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is registered this cycle |
| cmd_op | input | 3 | Command code: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 burst stop |
| cmd_bank | input | clog2(NUM_BANKS) | Target bank |
| cmd_row | input | ROW_W | Row to open on activate |
| cmd_ap | input | 1 | Auto precharge request for this read or write |
| full_page | input | 1 | Full-page burst mode, sampled at each read or write |
| bank_open | output | NUM_BANKS | One bit per bank: a row is open |
| bank_busy | output | NUM_BANKS | One bit per bank: bank cannot accept a command |
| bank_row | output | NUM_BANKS*ROW_W | Row last opened in each bank, bank 0 in the low bits |
| cmd_illegal | output | 1 | One-cycle pulse after a rejected command |

## Verification
The assertions assume that the command inputs hold known values whenever `cmd_valid` is high. They also assume that NUM_BANKS is a power of two, so every `cmd_bank` value names a real bank. The bench drives every input at the falling edge with defined values only, and it keeps the bank field inside the configured range. Beyond that, the stimulus is deliberately unconstrained: it issues commands to busy, closed and recovering banks, reserved op codes, and full-page and auto-precharge flags in any combination. Every rejection path therefore meets the assertions with legal input values.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4,
        OP_BST = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        BK_IDLE,
        BK_OPEN,
        BK_BURST,
        BK_BURST_AP,
        BK_STREAM,
        BK_RECOVER
    } bank_st_e;

endpackage

// File: rtl/sbt_cmd_decode.sv
module sbt_cmd_decode
    import sbt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic [BANK_W-1:0]    cmd_bank,
    input  logic [BANK_W-1:0]    last_bank,
    output logic [NUM_BANKS-1:0] act_sel,
    output logic [NUM_BANKS-1:0] rw_sel,
    output logic [NUM_BANKS-1:0] pre_sel,
    output logic [NUM_BANKS-1:0] bst_sel
);

    logic is_act, is_rw, is_pre, is_bst;

    always_comb begin
        is_act = cmd_valid && (cmd_op == OP_ACT);
        is_rw  = cmd_valid && ((cmd_op == OP_RD) || (cmd_op == OP_WR));
        is_pre = cmd_valid && (cmd_op == OP_PRE);
        is_bst = cmd_valid && (cmd_op == OP_BST);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
        assign act_sel[b] = is_act && (cmd_bank == BANK_W'(b));
        assign rw_sel[b]  = is_rw  && (cmd_bank == BANK_W'(b));
        assign pre_sel[b] = is_pre && (cmd_bank == BANK_W'(b));
        assign bst_sel[b] = is_bst && (last_bank == BANK_W'(b));
    end

endmodule

// File: rtl/sbt_last_access.sv
module sbt_last_access #(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rw_ok,
    input  logic [BANK_W-1:0] cmd_bank,
    output logic [BANK_W-1:0] last_bank
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_bank <= '0;
        end else if (rw_ok) begin
            last_bank <= cmd_bank;
        end
    end

endmodule

// File: rtl/sbt_bank_fsm.sv
module sbt_bank_fsm
    import sbt_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_act,
    input  logic             do_rw,
    input  logic             do_pre,
    input  logic             do_bst,
    input  logic [ROW_W-1:0] cmd_row,
    input  logic             cmd_ap,
    input  logic             full_page,
    output logic             reject,
    output logic             is_open,
    output logic             is_busy,
    output logic [ROW_W-1:0] row_q
);

    localparam int MAXC  = (BURST_LEN > T_RP) ? BURST_LEN : T_RP;
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC + 1) : 1;
    localparam logic [CNT_W-1:0] BL_LOAD = CNT_W'(BURST_LEN - 1);
    localparam logic [CNT_W-1:0] RP_LOAD = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    bank_st_e         state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Legality of the command aimed at this bank
    always_comb begin
        reject = 1'b0;
        unique case (state_q)
            BK_IDLE:                       reject = do_rw;
            BK_OPEN, BK_BURST, BK_STREAM:  reject = do_act;
            BK_BURST_AP:                   reject = do_act | do_rw | do_pre | do_bst;
            BK_RECOVER:                    reject = do_act | do_rw | do_pre;
            default:                       reject = 1'b0;
        endcase
    end

    // Next state: timers first, an accepted command overrides them
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            BK_BURST: begin
                if (cnt_q == '0) state_d = BK_OPEN;
                else             cnt_d   = cnt_q - ONE;
            end
            BK_BURST_AP: begin
                if (cnt_q == '0) begin
                    state_d = BK_RECOVER;
                    cnt_d   = RP_LOAD;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            BK_RECOVER: begin
                if (cnt_q == '0) state_d = BK_IDLE;
                else             cnt_d   = cnt_q - ONE;
            end
            default: ;
        endcase

        if (!reject) begin
            if (do_act) begin
                state_d = BK_OPEN;
            end else if (do_rw) begin
                if (full_page) begin
                    state_d = BK_STREAM;
                end else begin
                    state_d = cmd_ap ? BK_BURST_AP : BK_BURST;
                    cnt_d   = BL_LOAD;
                end
            end else if (do_pre && (state_q == BK_OPEN || state_q == BK_BURST ||
                                    state_q == BK_STREAM)) begin
                state_d = BK_RECOVER;
                cnt_d   = RP_LOAD;
            end else if (do_bst && (state_q == BK_BURST || state_q == BK_STREAM)) begin
                state_d = BK_OPEN;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Row capture on an accepted activate
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (do_act && !reject) begin
            row_q <= cmd_row;
        end
    end

    // Status outputs
    always_comb begin
        is_open = 1'b0;
        is_busy = 1'b0;
        unique case (state_q)
            BK_IDLE: ;
            BK_OPEN, BK_BURST, BK_STREAM: is_open = 1'b1;
            BK_BURST_AP: begin
                is_open = 1'b1;
                is_busy = 1'b1;
            end
            BK_RECOVER: is_busy = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sbt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 3,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [2:0]                 cmd_op,
    input  logic [BANK_W-1:0]          cmd_bank,
    input  logic [ROW_W-1:0]           cmd_row,
    input  logic                       cmd_ap,
    input  logic                       full_page,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS-1:0]       bank_busy,
    output logic [NUM_BANKS*ROW_W-1:0] bank_row,
    output logic                       cmd_illegal
);

    logic [NUM_BANKS-1:0] act_sel, rw_sel, pre_sel, bst_sel, reject;
    logic [BANK_W-1:0]    last_bank;
    logic                 any_reject;
    logic                 rw_ok;

    sbt_cmd_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_bank  (cmd_bank),
        .last_bank (last_bank),
        .act_sel   (act_sel),
        .rw_sel    (rw_sel),
        .pre_sel   (pre_sel),
        .bst_sel   (bst_sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [ROW_W-1:0] row_b;
        sbt_bank_fsm #(.ROW_W(ROW_W), .BURST_LEN(BURST_LEN), .T_RP(T_RP)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .do_act    (act_sel[b]),
            .do_rw     (rw_sel[b]),
            .do_pre    (pre_sel[b]),
            .do_bst    (bst_sel[b]),
            .cmd_row   (cmd_row),
            .cmd_ap    (cmd_ap),
            .full_page (full_page),
            .reject    (reject[b]),
            .is_open   (bank_open[b]),
            .is_busy   (bank_busy[b]),
            .row_q     (row_b)
        );
        assign bank_row[b*ROW_W +: ROW_W] = row_b;
    end

    assign any_reject = |reject;
    assign rw_ok      = (|rw_sel) && !any_reject;

    sbt_last_access #(.BANK_W(BANK_W)) u_last (
        .clk       (clk),
        .rst_n     (rst_n),
        .rw_ok     (rw_ok),
        .cmd_bank  (cmd_bank),
        .last_bank (last_bank)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_illegal <= 1'b0;
        else        cmd_illegal <= any_reject;
    end

endmodule

// File: rtl/sbt_checker.sv
module sbt_checker
    import sbt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 3,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cmd_valid,
    input logic [2:0]                 cmd_op,
    input logic [BANK_W-1:0]          cmd_bank,
    input logic [ROW_W-1:0]           cmd_row,
    input logic                       cmd_ap,
    input logic                       full_page,
    input logic [NUM_BANKS-1:0]       bank_open,
    input logic [NUM_BANKS-1:0]       bank_busy,
    input logic [NUM_BANKS*ROW_W-1:0] bank_row,
    input logic                       cmd_illegal
);

    // R2
    act_on_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ACT && bank_open[cmd_bank]) |=> cmd_illegal);

    // R3
    rw_on_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR) && !bank_open[cmd_bank])
        |=> cmd_illegal);

    // R4
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_illegal |-> $past(cmd_valid));

    // R10
    no_cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid || cmd_op == 3'd0 || cmd_op == 3'd6 || cmd_op == 3'd7) |=> !cmd_illegal);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        // R2
        act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_op == OP_ACT && cmd_bank == BANK_W'(b) &&
             !bank_open[b] && !bank_busy[b])
            |=> (bank_open[b] && bank_row[b*ROW_W +: ROW_W] == $past(cmd_row)));

        // R4
        row_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_op == OP_ACT && cmd_bank == BANK_W'(b) && bank_open[b])
            |=> $stable(bank_row[b*ROW_W +: ROW_W]));

        // R5
        ap_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR) && cmd_bank == BANK_W'(b) &&
             cmd_ap && !full_page && bank_open[b] && !bank_busy[b])
            |=> (bank_open[b] && bank_busy[b]));

        // R7
        full_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR) && cmd_bank == BANK_W'(b) &&
             full_page && bank_open[b] && !bank_busy[b])
            |=> (bank_open[b] && !bank_busy[b]));

        // R8
        pre_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_op == OP_PRE && cmd_bank == BANK_W'(b) &&
             bank_open[b] && !bank_busy[b])
            |=> (!bank_open[b] && bank_busy[b]));
    end

endmodule

bind sdram_bank_tracker sbt_checker #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .BURST_LEN (BURST_LEN),
    .T_RP      (T_RP)
) u_sbt_checker (.*);

// File: tb/tb_sdram_bank_tracker.sv
`timescale 1ns/1ps
module tb_sdram_bank_tracker;

    localparam int NB  = 4;
    localparam int RW  = 13;
    localparam int BL  = 4;
    localparam int TRP = 3;
    localparam int BW  = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [2:0]      cmd_op = '0;
    logic [BW-1:0]   cmd_bank = '0;
    logic [RW-1:0]   cmd_row = '0;
    logic            cmd_ap = 1'b0;
    logic            full_page = 1'b0;
    logic [NB-1:0]   bank_open, bank_busy;
    logic [NB*RW-1:0] bank_row;
    logic            cmd_illegal;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    sdram_bank_tracker #(.NUM_BANKS(NB), .ROW_W(RW), .BURST_LEN(BL), .T_RP(TRP)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_ap(cmd_ap), .full_page(full_page),
        .bank_open(bank_open), .bank_busy(bank_busy), .bank_row(bank_row),
        .cmd_illegal(cmd_illegal)
    );

    // Behavioural reference model
    bit m_open [NB];
    int m_row  [NB];
    int m_burst[NB];   // remaining burst cycles, -1 = full page
    bit m_ap   [NB];
    int m_rec  [NB];
    int m_last;
    bit m_ill;

    function automatic bit m_busy(int b);
        return (m_rec[b] > 0) || (m_ap[b] && m_burst[b] > 0);
    endfunction

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            m_open[b] = 0; m_row[b] = 0; m_burst[b] = 0; m_ap[b] = 0; m_rec[b] = 0;
        end
        m_last = 0;
        m_ill  = 0;
    endtask

    task automatic model_step();
        int  b;
        bit  ill;
        b   = int'(cmd_bank);
        ill = 0;
        if (cmd_valid) begin
            case (int'(cmd_op))
                1:       ill = m_open[b] || (m_rec[b] > 0);
                2, 3:    ill = !m_open[b] || m_busy(b);
                4:       ill = m_busy(b);
                5:       ill = m_ap[m_last] && (m_burst[m_last] > 0);
                default: ill = 0;
            endcase
        end
        for (int k = 0; k < NB; k++) begin
            if (m_rec[k] > 0) begin
                m_rec[k]--;
            end else if (m_burst[k] > 0) begin
                m_burst[k]--;
                if (m_burst[k] == 0 && m_ap[k]) begin
                    m_open[k] = 0; m_ap[k] = 0; m_rec[k] = TRP;
                end
            end
        end
        if (cmd_valid && !ill) begin
            case (int'(cmd_op))
                1: begin m_open[b] = 1; m_row[b] = int'(cmd_row); end
                2, 3: begin
                    if (full_page) begin m_burst[b] = -1; m_ap[b] = 0; end
                    else begin m_burst[b] = BL; m_ap[b] = cmd_ap; end
                    m_last = b;
                end
                4: if (m_open[b]) begin
                    m_open[b] = 0; m_burst[b] = 0; m_ap[b] = 0; m_rec[b] = TRP;
                end
                5: m_burst[m_last] = 0;
                default: ;
            endcase
        end
        m_ill = ill;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else        model_step();
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            for (int b = 0; b < NB; b++) begin
                if (bank_open[b] !== m_open[b]) begin
                    fails++;
                    $display("FAIL R2/R8 t=%0t bank %0d open act=%0b exp=%0b", $time, b, bank_open[b], m_open[b]);
                end
                if (bank_busy[b] !== m_busy(b)) begin
                    fails++;
                    $display("FAIL R5/R8 t=%0t bank %0d busy act=%0b exp=%0b", $time, b, bank_busy[b], m_busy(b));
                end
                if (bank_row[b*RW +: RW] !== RW'(m_row[b])) begin
                    fails++;
                    $display("FAIL R2 t=%0t bank %0d row act=%0h exp=%0h", $time, b, bank_row[b*RW +: RW], m_row[b]);
                end
            end
            if (cmd_illegal !== m_ill) begin
                fails++;
                $display("FAIL R4 t=%0t illegal act=%0b exp=%0b", $time, cmd_illegal, m_ill);
            end
        end
    end

    task automatic cmd(input bit v, input int op, input int bank, input int row,
                       input bit ap, input bit fp);
        @(negedge clk);
        cmd_valid = v;
        cmd_op    = op[2:0];
        cmd_bank  = bank[BW-1:0];
        cmd_row   = row[RW-1:0];
        cmd_ap    = ap;
        full_page = fp;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cmd(0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: outputs held at reset values
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        idle(2);

        // R2: open bank 0, then a second activate is refused (R4: row kept)
        cmd(1, 1, 0, 'h123, 0, 0);
        cmd(1, 1, 0, 'h0AA, 0, 0);
        // R3: read to closed bank 1
        cmd(1, 2, 1, 0, 0, 0);
        idle(1);

        // R5: read with auto precharge, then poke the bank while busy (R3, R2)
        cmd(1, 2, 0, 0, 1, 0);
        cmd(1, 3, 0, 0, 0, 0);
        idle(BL);
        cmd(1, 1, 0, 'h055, 0, 0);
        idle(TRP + 2);

        // R6: auto precharge does not persist
        cmd(1, 1, 0, 'h200, 0, 0);
        cmd(1, 2, 0, 0, 1, 0);
        idle(BL + TRP + 1);
        cmd(1, 1, 0, 'h201, 0, 0);
        cmd(1, 2, 0, 0, 0, 0);
        idle(BL + TRP + 2);

        // R7: full-page ignores the auto-precharge flag
        cmd(1, 2, 0, 0, 1, 1);
        idle(12);
        // R9: burst stop ends the stream, row stays open
        cmd(1, 5, 3, 0, 0, 0);
        idle(2);

        // R9: burst stop aimed at the latest access, which has auto precharge armed
        cmd(1, 1, 2, 'h777, 0, 0);
        cmd(1, 2, 0, 0, 0, 0);
        cmd(1, 3, 2, 0, 1, 0);
        cmd(1, 5, 0, 0, 0, 0);
        idle(BL + TRP + 2);

        // R8: precharge open, idle, and busy banks
        cmd(1, 4, 0, 0, 0, 0);
        cmd(1, 4, 0, 0, 0, 0);
        cmd(1, 4, 3, 0, 0, 0);
        idle(TRP + 1);

        // R10: reserved codes and strobe low
        cmd(1, 6, 1, 'h1, 1, 0);
        cmd(1, 7, 1, 'h2, 1, 1);
        cmd(0, 1, 1, 'h3, 0, 0);
        cmd(1, 0, 1, 'h4, 0, 0);
        idle(2);

        // R11: interleaved banks
        cmd(1, 1, 1, 'h011, 0, 0);
        cmd(1, 1, 2, 'h022, 0, 0);
        cmd(1, 2, 1, 0, 1, 0);
        cmd(1, 1, 3, 'h033, 0, 0);
        cmd(1, 3, 2, 0, 1, 0);
        cmd(1, 4, 3, 0, 0, 0);
        idle(BL + TRP + 3);

        // Unconstrained mix of all commands
        for (int i = 0; i < 4000; i++) begin
            cmd(($urandom % 4) != 0, int'($urandom_range(0, 7)), int'($urandom_range(0, NB-1)),
                int'($urandom_range(0, (1 << RW) - 1)), bit'($urandom % 2), ($urandom % 8) == 0);
        end
        idle(BL + TRP + 2);
        finish_run();
    end

endmodule